// File: doc/BRIEF.md
# I2C Dual-Target Register and Byte-Memory Slave

This block is an I2C target that answers at two bus addresses. One address leads to a bank of byte-wide configuration registers reached through a single pointer that advances by itself. The other address leads to an on-chip byte memory that takes a 16-bit location, sent as two bytes with the high byte first. Both targets share one bit engine that works from oversampled SCL and SDA. It detects START, repeated START and STOP, decodes the address byte, answers ACK or NACK, shifts data in and out, and pulls SDA low through an open-drain enable.

Bit 0 of the device address always comes from a pin. A parameter mask chooses which of bits 1 to 6 also come from pins. The rest come from a per-target base value. Memory writes stop while a write-disable input is high. Bit 0 of the last register removes the memory target from the bus.

Top module: `i2c_dual_target`

## Requirements
- R1: The register target answers at an address whose bits come from `addr_pin_i` where `PIN_MASK` is 1 (bit 0 always) and from `REG_BASE` elsewhere. With the defaults (`REG_BASE`=0x20, mask 0x07) it is {0100, pins[2:0]}. Pin bits outside the mask have no effect.
- R2: While enabled, the memory target answers at the address formed the same way from `MEM_BASE`. With the defaults (0x50) it is {1010, pins[2:0]}.
- R3: An address byte that matches neither target is NACKed. SDA is then left released until the next START, and later bytes are not acknowledged.
- R4: In a register write, the first data byte loads the pointer, modulo `NREG`. Each later byte is stored at the pointer, which then advances by one and wraps from `NREG`-1 to 0. Every byte is ACKed.
- R5: A register read returns register[pointer] for each byte, MSB first, and advances the pointer after each byte.
- R6: After a repeated START and a read address, data starts at the current pointer. Pointers keep their values across transactions.
- R7: In a memory write, the first two data bytes set the location, high byte first. Each later byte is stored at the location, which then advances. The memory is indexed by the low log2(`MEM_DEPTH`) bits of the location.
- R8: A memory read returns the byte at the current location and advances the location after each byte.
- R9: While `wr_dis_i` is high, memory data bytes are still ACKed and still advance the location, but the stored contents do not change.
- R10: While bit 0 of register `NREG`-1 is 1, the memory address is NACKed. The register target keeps working.
- R11: When the master NACKs a read byte, the block stops driving SDA and ignores bus traffic until the next START. A STOP or START always releases SDA.
- R12: After reset, SDA is released and all registers and both pointers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_pin_i | input | 7 | Address strap pins; bits used where PIN_MASK is 1 |
| wr_dis_i | input | 1 | High blocks all memory writes |

## Verification
The bench builds the block with `NREG`=16, `MEM_DEPTH`=256 and a three-pin address mask. With these values a register write of three bytes starting at pointer 14 crosses the wrap to 0 and lands a byte in the control register. The 16-bit memory location is wider than the 8-bit memory index, so a write at 0x01F0 can be read back at 0x00F0 to show the aliasing. The mask leaves pins 3 to 6 unused, so setting those bits shows they do not affect address matching.

// File: rtl/i2c_dt_pkg.sv
package i2c_dt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_MACK
  } phase_t;

  typedef enum logic { TGT_REG = 1'b0, TGT_MEM = 1'b1 } tgt_t;

  // bit 0 is always taken from the pin; the mask picks the others
  function automatic logic [6:0] dev_addr(input logic [6:0] base,
                                          input logic [6:0] mask,
                                          input logic [6:0] pins);
    logic [6:0] m;
    m = mask | 7'h01;
    return (base & ~m) | (pins & m);
  endfunction

  // saturating count of data bytes seen since the address byte
  function automatic logic [1:0] idx_step(input logic [1:0] idx);
    return (idx == 2'd2) ? idx : idx + 2'd1;
  endfunction

endpackage

// File: rtl/i2c_dt_sync.sv
module i2c_dt_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [2:0] scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  assign sda_s    = sda_p[1];
  assign scl_rise = scl_p[1] & ~scl_p[2];
  assign scl_fall = ~scl_p[1] & scl_p[2];
  assign ev_start = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  assign ev_stop  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
endmodule

// File: rtl/i2c_dt_regfile.sv
module i2c_dt_regfile #(
  parameter int NREG  = 16,
  parameter int PTR_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             mem_off
);
  logic [7:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 8'h00;
    end else if (we) begin
      regs[addr] <= wdata;
    end
  end

  assign rdata   = regs[addr];
  assign mem_off = regs[NREG-1][0];
endmodule

// File: rtl/i2c_dt_mem.sv
module i2c_dt_mem #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[addr] <= wdata;
  end

  assign rdata = arr[addr];
endmodule

// File: rtl/i2c_dual_target.sv
module i2c_dual_target
  import i2c_dt_pkg::*;
#(
  parameter int         NREG      = 16,
  parameter int         MEM_DEPTH = 256,
  parameter logic [6:0] REG_BASE  = 7'h20,
  parameter logic [6:0] MEM_BASE  = 7'h50,
  parameter logic [6:0] PIN_MASK  = 7'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [6:0] addr_pin_i,
  input  logic       wr_dis_i
);
  localparam int PTR_W = $clog2(NREG);
  localparam int MAW   = $clog2(MEM_DEPTH);

  // bus events
  logic sda_s, scl_rise, scl_fall, ev_start, ev_stop;

  i2c_dt_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  // protocol state
  phase_t           phase;
  tgt_t             tgt;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg;
  logic             rw_rd, mnack, sda_drv;
  logic [1:0]       wr_idx;
  logic [PTR_W-1:0] ptr;
  logic [15:0]      maddr;

  // named internal events
  logic [6:0] reg_dev, mem_dev;
  logic       mem_off, hit_reg, mem_match, hit_mem, addr_hit;
  logic       byte_rx_done, addr_done, addr_miss, mem_off_nack, data_done;
  logic       ptr_load, reg_we, mem_hi_load, mem_lo_load, mem_wr_try, mem_we;
  logic       wr_blocked, tx_load;
  logic [7:0] reg_rdata, mem_rdata, rd_byte;

  assign reg_dev   = dev_addr(REG_BASE, PIN_MASK, addr_pin_i);
  assign mem_dev   = dev_addr(MEM_BASE, PIN_MASK, addr_pin_i);
  assign hit_reg   = (shreg[7:1] == reg_dev);
  assign mem_match = (shreg[7:1] == mem_dev);
  assign hit_mem   = mem_match & ~mem_off;
  assign addr_hit  = hit_reg | hit_mem;

  assign byte_rx_done = scl_fall && (bit_cnt == 4'd8) &&
                        ((phase == ST_ADDR) || (phase == ST_RX));
  assign addr_done    = byte_rx_done && (phase == ST_ADDR);
  assign addr_miss    = addr_done && !addr_hit;
  assign mem_off_nack = addr_done && mem_match && mem_off && !hit_reg;
  assign data_done    = byte_rx_done && (phase == ST_RX);

  assign ptr_load    = data_done && (tgt == TGT_REG) && (wr_idx == 2'd0);
  assign reg_we      = data_done && (tgt == TGT_REG) && (wr_idx != 2'd0);
  assign mem_hi_load = data_done && (tgt == TGT_MEM) && (wr_idx == 2'd0);
  assign mem_lo_load = data_done && (tgt == TGT_MEM) && (wr_idx == 2'd1);
  assign mem_wr_try  = data_done && (tgt == TGT_MEM) && (wr_idx == 2'd2);
  assign mem_we      = mem_wr_try && !wr_dis_i;
  assign wr_blocked  = mem_wr_try && wr_dis_i;

  assign tx_load = scl_fall &&
                   (((phase == ST_AACK) && rw_rd) || ((phase == ST_MACK) && !mnack));
  assign rd_byte = (tgt == TGT_REG) ? reg_rdata : mem_rdata;

  i2c_dt_regfile #(.NREG(NREG), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(ptr), .wdata(shreg),
    .rdata(reg_rdata), .mem_off(mem_off)
  );

  i2c_dt_mem #(.DEPTH(MEM_DEPTH), .AW(MAW)) u_mem (
    .clk(clk), .we(mem_we), .addr(maddr[MAW-1:0]), .wdata(shreg),
    .rdata(mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= ST_IDLE;
      tgt     <= TGT_REG;
      bit_cnt <= 4'd0;
      shreg   <= 8'h00;
      rw_rd   <= 1'b0;
      mnack   <= 1'b0;
      sda_drv <= 1'b0;
      wr_idx  <= 2'd0;
      ptr     <= '0;
      maddr   <= 16'h0000;
    end else if (ev_start) begin
      phase   <= ST_ADDR;
      bit_cnt <= 4'd0;
      sda_drv <= 1'b0;
      wr_idx  <= 2'd0;
    end else if (ev_stop) begin
      phase   <= ST_IDLE;
      sda_drv <= 1'b0;
    end else begin
      // register pointer
      if (ptr_load)
        ptr <= shreg[PTR_W-1:0];
      else if (reg_we || (tx_load && (tgt == TGT_REG)))
        ptr <= ptr + 1'b1;
      // memory location
      if (mem_hi_load)
        maddr <= {shreg, maddr[7:0]};
      else if (mem_lo_load)
        maddr <= {maddr[15:8], shreg};
      else if (mem_wr_try || (tx_load && (tgt == TGT_MEM)))
        maddr <= maddr + 16'd1;

      case (phase)
        ST_ADDR, ST_RX: begin
          if (scl_rise && (bit_cnt != 4'd8)) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_rx_done) begin
            if (phase == ST_RX) begin
              phase   <= ST_RACK;
              sda_drv <= 1'b1;
              wr_idx  <= idx_step(wr_idx);
            end else if (addr_hit) begin
              phase   <= ST_AACK;
              sda_drv <= 1'b1;
              rw_rd   <= shreg[0];
              tgt     <= hit_reg ? TGT_REG : TGT_MEM;
            end else begin
              phase <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            bit_cnt <= 4'd0;
            if (rw_rd) begin
              phase   <= ST_TX;
              shreg   <= rd_byte;
              sda_drv <= ~rd_byte[7];
            end else begin
              phase   <= ST_RX;
              sda_drv <= 1'b0;
            end
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            phase   <= ST_RX;
            bit_cnt <= 4'd0;
            sda_drv <= 1'b0;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            bit_cnt <= bit_cnt + 4'd1;
            if (bit_cnt == 4'd7) begin
              phase   <= ST_MACK;
              sda_drv <= 1'b0;
            end else begin
              shreg   <= {shreg[6:0], 1'b0};
              sda_drv <= ~shreg[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mnack <= sda_s;
          end else if (scl_fall) begin
            bit_cnt <= 4'd0;
            if (mnack) begin
              phase <= ST_IDLE;
            end else begin
              phase   <= ST_TX;
              shreg   <= rd_byte;
              sda_drv <= ~rd_byte[7];
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_drv;
endmodule

// File: rtl/i2c_dt_chk.sv
module i2c_dt_chk #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe_o,
  input logic             wr_dis_i,
  input logic             ev_start,
  input logic             ev_stop,
  input logic             reg_we,
  input logic             mem_we,
  input logic             wr_blocked,
  input logic             addr_miss,
  input logic             mem_off_nack,
  input logic [PTR_W-1:0] ptr
);
  // R9
  wd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis_i |-> !mem_we);

  // R9
  blocked_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> sda_oe_o);

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (ptr == $past(ptr) + 1'b1));

  // R3
  miss_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !sda_oe_o);

  // R10
  mem_off_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_off_nack |=> !sda_oe_o);

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe_o);

  // R11
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe_o);

  // R7
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, mem_we}));
endmodule

bind i2c_dual_target i2c_dt_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .wr_dis_i(wr_dis_i),
  .ev_start(ev_start), .ev_stop(ev_stop), .reg_we(reg_we), .mem_we(mem_we),
  .wr_blocked(wr_blocked), .addr_miss(addr_miss),
  .mem_off_nack(mem_off_nack), .ptr(ptr)
);

// File: tb/sim_i2c_dual_target.sv
module sim_i2c_dual_target;
  localparam int QTR = 10;
  localparam logic [6:0] RB = 7'h20;
  localparam logic [6:0] MB = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wr_dis = 1'b0;
  logic [6:0] pins = 7'b0000101;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_dual_target #(.NREG(16), .MEM_DEPTH(256), .REG_BASE(RB),
                    .MEM_BASE(MB), .PIN_MASK(7'h07)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .addr_pin_i(pins), .wr_dis_i(wr_dis)
  );

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t      exp_q [$];
  logic [7:0] act_q [$];

  logic [7:0] reg_m [16];
  logic [7:0] mem_m [256];
  logic [3:0] ptr_m = 4'd0;
  logic [15:0] maddr_m = 16'd0;

  // address per requirement text: upper four bits from base, low three from pins
  function automatic logic [6:0] bus_addr(input logic [6:0] base, input logic [6:0] p);
    return {base[6:3], p[2:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic q(); repeat (QTR) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q(); endtask
  task automatic bus_stop(); sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q(); q(); endtask
  task automatic put_bit(input logic b); sda_m = b; q(); scl_m = 1; q(); q(); scl_m = 0; q(); endtask
  task automatic get_bit(output logic b);
    sda_m = 1; q(); scl_m = 1; q(); b = sda_bus; q(); scl_m = 0; q();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic rd_n(input int n);
    logic [7:0] d;
    logic b;
    for (int k = 0; k < n; k++) begin
      for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
      put_bit(k == n - 1);
      act_q.push_back(d);
    end
  endtask

  task automatic push_exp(input logic [7:0] v, input string tag);
    item_t it;
    it.v = v; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic reg_wr(input logic [7:0] p, input int n, input logic [7:0] d0,
                        input logic [7:0] d1, input logic [7:0] d2, input string tag);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({bus_addr(RB, pins), 1'b0}, ack); chk(ack, "R1", ack, 1);
    send_byte(p, ack); chk(ack, tag, ack, 1);
    ptr_m = p[3:0];
    for (int k = 0; k < n; k++) begin
      d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
      send_byte(d, ack); chk(ack, tag, ack, 1);
      reg_m[ptr_m] = d;
      ptr_m = ptr_m + 4'd1;
    end
    bus_stop();
  endtask

  task automatic reg_rd_from(input logic [7:0] p, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte({bus_addr(RB, pins), 1'b0}, ack); chk(ack, "R1", ack, 1);
    send_byte(p, ack); chk(ack, "R4", ack, 1);
    ptr_m = p[3:0];
    bus_start();
    send_byte({bus_addr(RB, pins), 1'b1}, ack); chk(ack, "R6", ack, 1);
    for (int k = 0; k < n; k++) begin push_exp(reg_m[ptr_m], tag); ptr_m = ptr_m + 4'd1; end
    rd_n(n);
    bus_stop();
  endtask

  task automatic reg_rd_cur(input int n, input string tag, input bit do_stop);
    logic ack;
    bus_start();
    send_byte({bus_addr(RB, pins), 1'b1}, ack); chk(ack, "R1", ack, 1);
    for (int k = 0; k < n; k++) begin push_exp(reg_m[ptr_m], tag); ptr_m = ptr_m + 4'd1; end
    rd_n(n);
    if (do_stop) bus_stop();
  endtask

  task automatic mem_wr(input logic [15:0] a, input int n, input logic [7:0] d0,
                        input logic [7:0] d1, input logic [7:0] d2, input string tag);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({bus_addr(MB, pins), 1'b0}, ack); chk(ack, "R2", ack, 1);
    send_byte(a[15:8], ack); chk(ack, "R7", ack, 1);
    send_byte(a[7:0], ack); chk(ack, "R7", ack, 1);
    maddr_m = a;
    for (int k = 0; k < n; k++) begin
      d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
      send_byte(d, ack); chk(ack, tag, ack, 1);
      if (!wr_dis) mem_m[maddr_m[7:0]] = d;
      maddr_m = maddr_m + 16'd1;
    end
    bus_stop();
  endtask

  task automatic mem_rd_from(input logic [15:0] a, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte({bus_addr(MB, pins), 1'b0}, ack); chk(ack, "R2", ack, 1);
    send_byte(a[15:8], ack); chk(ack, "R8", ack, 1);
    send_byte(a[7:0], ack); chk(ack, "R8", ack, 1);
    maddr_m = a;
    bus_start();
    send_byte({bus_addr(MB, pins), 1'b1}, ack); chk(ack, "R8", ack, 1);
    for (int k = 0; k < n; k++) begin push_exp(mem_m[maddr_m[7:0]], tag); maddr_m = maddr_m + 16'd1; end
    rd_n(n);
    bus_stop();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // monitor: compare read bytes against the scoreboard
  initial begin
    item_t e;
    logic [7:0] a;
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        a = act_q.pop_front();
        if (exp_q.size() == 0) chk(0, "unexpected read", a, 0);
        else begin
          e = exp_q.pop_front();
          chk(a === e.v, e.tag, a, e.v);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic ack;
    for (int i = 0; i < 16; i++) reg_m[i] = 8'h00;
    for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R12: released after reset, registers and pointer zero
    chk(sda_oe == 1'b0, "R12", sda_oe, 0);
    reg_rd_cur(2, "R12", 1'b1);

    // R4 / R5 / R6: write three bytes at 3, read back after repeated START
    reg_wr(8'h03, 3, 8'hA1, 8'hB2, 8'hC3, "R4");
    reg_rd_from(8'h03, 3, "R6");
    // R5: pointer continued past the last read byte
    reg_rd_cur(1, "R5", 1'b1);

    // R4: wrap from 15 to 0
    reg_wr(8'h0E, 3, 8'h11, 8'h22, 8'h33, "R4");
    reg_rd_from(8'h0E, 3, "R4");

    // R3: non-matching addresses are NACKed, later bytes ignored
    bus_start();
    send_byte({bus_addr(RB, pins) ^ 7'h02, 1'b0}, ack); chk(!ack, "R3", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R3", ack, 0);
    bus_stop();
    bus_start();
    send_byte({7'h30, 1'b1}, ack); chk(!ack, "R3", ack, 0);
    bus_stop();

    // R7 / R8: memory write then read back
    mem_wr(16'h0010, 3, 8'h9C, 8'h4D, 8'hE7, "R7");
    mem_rd_from(16'h0010, 3, "R8");
    mem_wr(16'h01F0, 1, 8'h5A, 8'h00, 8'h00, "R7");
    mem_rd_from(16'h00F0, 1, "R7");

    // R9: blocked writes are ACKed but leave contents unchanged
    wr_dis = 1'b1;
    mem_wr(16'h0010, 2, 8'hFF, 8'hFF, 8'h00, "R9");
    wr_dis = 1'b0;
    mem_rd_from(16'h0010, 2, "R9");

    // R10: control bit removes the memory target
    reg_wr(8'h0F, 1, 8'h01, 8'h00, 8'h00, "R10");
    bus_start();
    send_byte({bus_addr(MB, pins), 1'b0}, ack); chk(!ack, "R10", ack, 0);
    bus_stop();
    reg_rd_from(8'h0F, 1, "R10");
    reg_wr(8'h0F, 1, 8'h00, 8'h00, 8'h00, "R10");
    mem_rd_from(16'h0011, 1, "R10");

    // R11: after master NACK the block ignores further bytes
    reg_wr(8'h04, 0, 8'h00, 8'h00, 8'h00, "R11");
    reg_rd_cur(1, "R11", 1'b0);
    send_byte(8'h00, ack); chk(!ack, "R11", ack, 0);
    bus_stop();
    chk(sda_oe == 1'b0, "R11", sda_oe, 0);

    // R1: address follows the pins; unmasked pin bits ignored
    pins = 7'b1111010;
    reg_rd_cur(1, "R1", 1'b1);
    bus_start();
    send_byte({7'h25, 1'b1}, ack); chk(!ack, "R1", ack, 0);
    bus_stop();
    pins = 7'b0000101;

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule